// File: doc/BRIEF.md
# Data-Ready Pin Generator

This block turns the conversion-complete strobes of a multi-channel ADC into one data-ready pin for a host. Each channel has a sticky status bit. The bit sets when an enabled channel strobes and stays set until the host reads a frame, which a single-cycle read-clear input represents. The pin is built from the enabled channels in one of three ways:

- **Lagging:** the pin waits until every enabled channel has new data.
- **Leading:** the pin reacts to the first enabled channel.
- **Any:** the pin follows the OR of all enabled channels.

The host sets the pin style at run time. In level style the pin is held low until the next read-clear. In pulse style the pin gives a low pulse of fixed width. When nothing is pending, the pin is either driven high or released, which sets the output-enable low. The channel count and the pulse width are parameters. The modulators, the filters and the serial port are outside this block.

Top module: `drdy_pin_gen`

## Requirements
- R1: After reset every status bit is 0 and the pin is not asserted: `pin_out` = 1, and `pin_oe` = 1 when `idle_hiz` = 0.
- R2: A strobe on an enabled channel sets that channel's status bit (`status_ready[i]` for channel i) one cycle later. The bit stays at 1 until a read-clear.
- R3: A strobe on a channel whose `ch_enable` bit is 0 leaves that channel's status bit unchanged.
- R4: A read-clear sets all status bits to 0 one cycle later. A strobe in the same cycle as a read-clear is lost.
- R5: `src_mode` = 00 (lagging): the pin asserts two cycles after the strobe that completes the set of enabled channels, and not before.
- R6: `src_mode` = 01 (any): in level style the pin asserts two cycles after the first enabled strobe. In pulse style each enabled channel's status bit changing from 0 to 1 starts a pulse.
- R7: `src_mode` = 10 or 11 (leading): the pin asserts two cycles after the first enabled strobe after a read-clear. In pulse style there is only one pulse per read-clear window.
- R8: `pulse_fmt` = 0 (level): the pin stays asserted until a read-clear and is idle one cycle after the read-clear.
- R9: `pulse_fmt` = 1 (pulse): the pin is low for exactly PULSE_W cycles. An event during a pulse neither lengthens it nor starts a new one. A read-clear does not cut a pulse short.
- R10: An asserted pin has `pin_out` = 0 and `pin_oe` = 1. An idle pin has `pin_out` = 1 and `pin_oe` = NOT `idle_hiz`.
- R11: With every channel disabled, no status bit sets and the pin stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_strobe | input | NUM_CH | Per-channel conversion-complete strobe |
| ch_enable | input | NUM_CH | Per-channel enable |
| src_mode | input | 2 | Pin source: 00 lagging, 01 any, 10/11 leading |
| pulse_fmt | input | 1 | 0 level style, 1 fixed low pulse |
| idle_hiz | input | 1 | 1 releases the pin when idle |
| rd_clear | input | 1 | Host frame read; clears the status bits |
| pin_out | output | 1 | Data-ready pin value (low = data available) |
| pin_oe | output | 1 | Data-ready pin output enable |
| status_ready | output | NUM_CH | Sticky per-channel new-data bits |

## Verification
Each status bit is due one cycle after the strobe that sets it. The pin is due two cycles after that strobe: one register for status and one for the pin stage. The level-style release is due one cycle after a read-clear. The bench drives inputs on the falling edge and samples on a later falling edge, so every expected value refers to a known count of rising edges. It sweeps all modes, enable masks, styles and idle states, with strobes spaced PULSE_W+2 cycles apart. This lets the expected pulse windows be computed as disjoint intervals from each channel's strobe time.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
   typedef enum logic [1:0] {
      SRC_LAG      = 2'b00,
      SRC_ANY      = 2'b01,
      SRC_LEAD     = 2'b10,
      SRC_LEAD_ALT = 2'b11
   } src_mode_e;
endpackage

// File: rtl/drdy_status_bank.sv
module drdy_status_bank #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] strobe,
   input  logic [NUM_CH-1:0] enable,
   input  logic              rd_clear,
   output logic [NUM_CH-1:0] ready
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                      bit_q <= 1'b0;
         else if (rd_clear)               bit_q <= 1'b0;
         else if (strobe[i] && enable[i]) bit_q <= 1'b1;
      end
      assign ready[i] = bit_q;

      // R2: a set bit holds until a read-clear
      a_r2_sticky : assert property (@(posedge clk) disable iff (!rst_n)
         (ready[i] && !rd_clear) |=> ready[i]);
      // R3: a bit only rises on an enabled strobe
      a_r3_no_spurious_set : assert property (@(posedge clk) disable iff (!rst_n)
         (!ready[i] && !(strobe[i] && enable[i])) |=> !ready[i]);
   end

   // R4: read-clear empties the bank
   a_r4_clear : assert property (@(posedge clk) disable iff (!rst_n)
      rd_clear |=> (ready == '0));
endmodule

// File: rtl/drdy_source_sel.sv
module drdy_source_sel
   import drdy_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ready,
   input  logic [NUM_CH-1:0] enable,
   input  logic [1:0]        mode,
   output logic              level_cond,
   output logic              event_pulse
);
   src_mode_e         mode_e;
   logic              any_en;
   logic              all_cond;
   logic              any_cond;
   logic              cond_q;
   logic [NUM_CH-1:0] ready_prev;
   logic [NUM_CH-1:0] fresh;

   assign mode_e   = src_mode_e'(mode);
   assign any_en   = |enable;
   assign all_cond = any_en && (&(ready | ~enable));
   assign any_cond = |(ready & enable);
   assign fresh    = ready & ~ready_prev & enable;

   always_comb begin
      unique case (mode_e)
         SRC_LAG: level_cond = all_cond;
         default: level_cond = any_cond;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cond_q     <= 1'b0;
         ready_prev <= '0;
      end else begin
         cond_q     <= level_cond;
         ready_prev <= ready;
      end
   end

   always_comb begin
      if (mode_e == SRC_ANY) event_pulse = |fresh;
      else                   event_pulse = level_cond && !cond_q;
   end

   // R11: nothing qualifies with every channel disabled
   a_r11_all_off : assert property (@(posedge clk) disable iff (!rst_n)
      (enable == '0) |-> (!level_cond && !event_pulse));
   // R5: lagging source never fires while an enabled channel is still empty
   a_r5_lag_waits : assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b00) && ((~ready & enable) != '0)) |-> !level_cond);
endmodule

// File: rtl/drdy_pin_shaper.sv
module drdy_pin_shaper #(
   parameter int PULSE_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_cond,
   input  logic event_pulse,
   input  logic pulse_fmt,
   input  logic rd_clear,
   output logic asserted
);
   logic level_q;
   logic pulse_on;

   always_ff @(posedge clk) begin
      if (!rst_n)        level_q <= 1'b0;
      else if (rd_clear) level_q <= 1'b0;
      else               level_q <= level_cond;
   end

   if (PULSE_W == 1) begin : g_single
      logic p_q;
      always_ff @(posedge clk) begin
         if (!rst_n) p_q <= 1'b0;
         else        p_q <= event_pulse && !p_q;
      end
      assign pulse_on = p_q;
   end else begin : g_count
      localparam int CW = $clog2(PULSE_W + 1);
      localparam logic [CW-1:0] LOAD = CW'(PULSE_W);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)              cnt_q <= '0;
         else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         else if (event_pulse)    cnt_q <= LOAD;
      end
      assign pulse_on = (cnt_q != '0);

      // R9: counter stays within the programmed width
      a_r9_bound : assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LOAD);
      // R9: a running pulse only counts down, never reloads
      a_r9_no_extend : assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q != '0) |=> (cnt_q < $past(cnt_q)));
   end

   assign asserted = pulse_fmt ? pulse_on : level_q;

   // R8: level style releases one cycle after a read-clear
   a_r8_level_release : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && !pulse_fmt) |=> (!pulse_fmt -> !asserted));
endmodule

// File: rtl/drdy_pin_gen.sv
module drdy_pin_gen #(
   parameter int NUM_CH  = 4,
   parameter int PULSE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_strobe,
   input  logic [NUM_CH-1:0] ch_enable,
   input  logic [1:0]        src_mode,
   input  logic              pulse_fmt,
   input  logic              idle_hiz,
   input  logic              rd_clear,
   output logic              pin_out,
   output logic              pin_oe,
   output logic [NUM_CH-1:0] status_ready
);
   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("NUM_CH out of range");
   end
   if (PULSE_W < 1) begin : g_bad_pw
      $error("PULSE_W must be at least 1");
   end

   logic level_cond;
   logic event_pulse;
   logic asserted;

   drdy_status_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk(clk), .rst_n(rst_n), .strobe(ch_strobe), .enable(ch_enable),
      .rd_clear(rd_clear), .ready(status_ready)
   );

   drdy_source_sel #(.NUM_CH(NUM_CH)) u_sel (
      .clk(clk), .rst_n(rst_n), .ready(status_ready), .enable(ch_enable),
      .mode(src_mode), .level_cond(level_cond), .event_pulse(event_pulse)
   );

   drdy_pin_shaper #(.PULSE_W(PULSE_W)) u_shape (
      .clk(clk), .rst_n(rst_n), .level_cond(level_cond),
      .event_pulse(event_pulse), .pulse_fmt(pulse_fmt),
      .rd_clear(rd_clear), .asserted(asserted)
   );

   assign pin_out = !asserted;
   assign pin_oe  = asserted || !idle_hiz;

   // R10: a released pin is never driven low
   a_r10_hiz_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (idle_hiz && pin_out) |-> !pin_oe);
   // R10: a low pin is always driven
   a_r10_low_driven : assert property (@(posedge clk) disable iff (!rst_n)
      !pin_out |-> pin_oe);
endmodule

// File: tb/drdy_pin_gen_tb.sv
module drdy_pin_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int PW  = 2;
   localparam int GAP = PW + 2;
   localparam int T   = 3 * GAP + PW + 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] ch_strobe = '0;
   logic [NCH-1:0] ch_enable = '1;
   logic [1:0]     src_mode = 2'b00;
   logic           pulse_fmt = 1'b0;
   logic           idle_hiz = 1'b0;
   logic           rd_clear = 1'b0;
   logic           pin_out, pin_oe;
   logic [NCH-1:0] status_ready;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   drdy_pin_gen #(.NUM_CH(NCH), .PULSE_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ch_strobe(ch_strobe), .ch_enable(ch_enable),
      .src_mode(src_mode), .pulse_fmt(pulse_fmt), .idle_hiz(idle_hiz),
      .rd_clear(rd_clear), .pin_out(pin_out), .pin_oe(pin_oe),
      .status_ready(status_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_pin(input bit exp_low, input bit hiz, input string req);
      logic exp_out, exp_oe;
      exp_out = !exp_low;
      exp_oe  = exp_low || !hiz;
      chk(pin_out == exp_out, req, pin_out, exp_out);
      chk(pin_oe == exp_oe, exp_low ? req : "R10", pin_oe, exp_oe);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(status_ready == '0, "R1", status_ready, 0);
      chk_pin(1'b0, 1'b0, "R1");

      // sweep all modes, masks, styles, idle states
      for (int m = 0; m < 4; m++)
      for (int msk = 0; msk < 16; msk++)
      for (int f = 0; f < 2; f++)
      for (int h = 0; h < 2; h++) begin
         int fi, la;
         string tag;
         fi = -1; la = -1;
         for (int i = 0; i < NCH; i++)
            if (msk[i]) begin
               if (fi < 0) fi = i;
               la = i;
            end
         tag = (msk == 0) ? "R11" : (m == 0) ? "R5" : (m == 1) ? "R6" : "R7";
         @(negedge clk);
         src_mode = 2'(m); ch_enable = 4'(msk); pulse_fmt = f[0]; idle_hiz = h[0];
         for (int t = 0; t <= T; t++) begin
            bit low;
            int key;
            @(negedge clk);
            // status: set one cycle after an enabled strobe (R2), never for a disabled one (R3)
            for (int i = 0; i < NCH; i++) begin
               bit eb;
               eb = msk[i] && (t >= i * GAP + 1);
               chk(status_ready[i] == eb, msk[i] ? "R2" : "R3", status_ready[i], eb);
            end
            low = 1'b0;
            if (msk != 0) begin
               key = (m == 0) ? la * GAP : fi * GAP;
               if (f == 0) low = (t >= key + 2);
               else if (m == 1) begin
                  for (int i = 0; i < NCH; i++)
                     if (msk[i] && t >= i * GAP + 2 && t <= i * GAP + 1 + PW) low = 1'b1;
               end else low = (t >= key + 2 && t <= key + 1 + PW);
            end
            chk_pin(low, h[0], tag);
            ch_strobe = '0;
            for (int i = 0; i < NCH; i++)
               if (t == i * GAP) ch_strobe[i] = 1'b1;
         end
         @(negedge clk);
         ch_strobe = '0;
         rd_clear = 1'b1;
         @(negedge clk);
         rd_clear = 1'b0;
         chk(status_ready == '0, "R4", status_ready, 0);
         chk_pin(1'b0, h[0], "R8");
      end

      // R9: event during a pulse does not lengthen it
      @(negedge clk);
      src_mode = 2'b01; ch_enable = '1; pulse_fmt = 1'b1; idle_hiz = 1'b0;
      ch_strobe = 4'b0001;
      @(negedge clk);
      ch_strobe = 4'b0010;
      @(negedge clk);
      ch_strobe = '0;
      chk_pin(1'b1, 1'b0, "R9");
      @(negedge clk);
      chk_pin(1'b1, 1'b0, "R9");
      @(negedge clk);
      chk_pin(1'b0, 1'b0, "R9");
      @(negedge clk);
      chk_pin(1'b0, 1'b0, "R9");
      rd_clear = 1'b1;
      @(negedge clk);
      rd_clear = 1'b0;

      // R4: strobe together with read-clear is lost
      ch_strobe = 4'b0100;
      rd_clear = 1'b1;
      @(negedge clk);
      ch_strobe = '0;
      rd_clear = 1'b0;
      chk(status_ready == '0, "R4", status_ready, 0);
      @(negedge clk);
      chk(status_ready == '0, "R4", status_ready, 0);

      // R8: level style held across many idle cycles until read-clear
      pulse_fmt = 1'b0; src_mode = 2'b10;
      ch_strobe = 4'b1000;
      @(negedge clk);
      ch_strobe = '0;
      repeat (10) @(negedge clk);
      chk_pin(1'b1, 1'b0, "R8");
      rd_clear = 1'b1;
      @(negedge clk);
      rd_clear = 1'b0;
      chk_pin(1'b0, 1'b0, "R8");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule